// File: doc/BRIEF.md
# Cell Filter and Extraction Queue

This block inspects the header of each downstream cell and decides whether the cell is diverted away from the normal path. Each header carries a 16-bit virtual channel identifier and a 3-bit payload type. Two masked comparators watch the channel identifier and two more watch the payload type. Each comparator has its own enable. A cell is diverted when at least one enabled comparator matches. For each accepted header the block reports the decision one cycle later on a divert strobe.

Diverted headers are written into a ring of slots held on chip. The ring covers slot addresses 2 through 255. A host reads the ring through a read pointer that it can see and also load, and it drains entries over a valid/ready port. Full and not-empty flags feed a sticky status register. The status register clears when it is read, and its contents drive an interrupt. A diverted cell that finds the ring full is dropped and counted.

The header input is valid/ready, and `in_ready` is held high at all times. Back-pressure never stalls the cell stream: when the ring is full, the matching cell is dropped rather than held. On the drain side, an entry leaves the ring only in a cycle where `q_valid` and `q_ready` are both high.

Top module: `cell_filter_xq`

## Requirements
- R1: VCI comparator k (k = 0, 1) matches when ((in_vci XOR vci_patk) AND NOT vci_mskk) == 0. A mask bit of 1 therefore makes that bit don't-care. The comparator counts only when vci_en[k] is 1.
- R2: PT comparator k matches when ((in_pt XOR pt_patk) AND NOT pt_mskk) == 0. It counts only when pt_en[k] is 1.
- R3: in_ready is always 1. In the cycle after a cycle with in_valid high, div_valid is 1, and div_hit is the OR of all enabled comparator matches. If no comparator is enabled, div_hit is 0. When in_valid is low, div_valid is 0 in the next cycle.
- R4: A diverted cell that finds the ring not full stores {in_pt, in_vci} (PT in bits 18:16, VCI in bits 15:0) at slot wr_ptr. wr_ptr then advances by one, wrapping from 255 to 2.
- R5: After reset, rd_ptr and wr_ptr are both 2, flag_full and flag_ne are 0, stat_q is 0, irq is 0 and drop_cnt is 0.
- R6: flag_ne and q_valid are 1 exactly when rd_ptr differs from wr_ptr. q_data is the entry stored at slot rd_ptr. A cycle with q_valid and q_ready both high advances rd_ptr by one with the same wrap. q_ready while the ring is empty leaves rd_ptr unchanged.
- R7: flag_full is 1 when advancing wr_ptr would reach rd_ptr, so at most 253 entries are resident. A diverted cell that arrives while flag_full is 1 is not stored, wr_ptr does not move, and drop_cnt increases by one (saturating at its maximum).
- R8: rp_load writes rp_value into rd_ptr, and a value below 2 becomes 2. rp_load takes priority over a pop in the same cycle.
- R9: stat_q[0] is set one cycle after flag_ne rises, and stat_q[1] is set one cycle after flag_full rises. Both bits hold until a cycle with stat_rd high, which clears them; a set event in that same cycle wins. irq is 1 whenever stat_q is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Header valid |
| in_ready | output | 1 | Header ready, constant 1 |
| in_vci | input | 16 | Header channel identifier |
| in_pt | input | 3 | Header payload type |
| vci_pat0 | input | 16 | VCI pattern 0 |
| vci_msk0 | input | 16 | VCI mask 0 (1 = ignore bit) |
| vci_pat1 | input | 16 | VCI pattern 1 |
| vci_msk1 | input | 16 | VCI mask 1 |
| vci_en | input | 2 | VCI comparator enables |
| pt_pat0 | input | 3 | PT pattern 0 |
| pt_msk0 | input | 3 | PT mask 0 |
| pt_pat1 | input | 3 | PT pattern 1 |
| pt_msk1 | input | 3 | PT mask 1 |
| pt_en | input | 2 | PT comparator enables |
| div_valid | output | 1 | Divert decision valid |
| div_hit | output | 1 | Cell diverted |
| q_valid | output | 1 | Ring entry available at rd_ptr |
| q_ready | input | 1 | Host consumes entry |
| q_data | output | 19 | Entry at rd_ptr, {pt, vci} |
| rd_ptr | output | 8 | Read pointer |
| wr_ptr | output | 8 | Write pointer |
| rp_load | input | 1 | Load read pointer |
| rp_value | input | 8 | Read pointer load value |
| flag_full | output | 1 | Ring full |
| flag_ne | output | 1 | Ring not empty |
| stat_rd | input | 1 | Status read, clears stat_q |
| stat_q | output | 2 | Sticky status {full seen, not-empty seen} |
| irq | output | 1 | Interrupt |
| drop_cnt | output | 8 | Dropped diverted cells |

## Verification
The bench sweeps every pattern, mask and header combination of both payload-type comparators. It also sweeps masked nibbles of the channel identifier on both channel-identifier comparators. A mask of inverted sense, or an enable wired to the wrong comparator, would flip many of these decisions. The bench fills the ring to 253 entries and pushes further matches. A design that overwrites entries when full would change wr_ptr or corrupt the oldest entry, and one that miscounts capacity would raise full one entry early or late. It also checks the wrap of both pointers from 255 to 2, the clamping of a read-pointer load below 2, load priority over a simultaneous pop, and the clearing of the status register on read.

// File: rtl/cf_pkg.sv
package cf_pkg;
  localparam int VCI_W = 16;
  localparam int PT_W  = 3;
  localparam int HDR_W = VCI_W + PT_W;

  typedef struct packed {
    logic [PT_W-1:0]  pt;
    logic [VCI_W-1:0] vci;
  } cf_hdr_t;
endpackage

// File: rtl/cf_match.sv
module cf_match #(
  parameter int W = 16,
  parameter int N = 2
) (
  input  logic [W-1:0]   val,
  input  logic [N*W-1:0] pat,
  input  logic [N*W-1:0] msk,
  input  logic [N-1:0]   en,
  output logic [N-1:0]   hit
);
  for (genvar k = 0; k < N; k++) begin : g_cmp
    logic [W-1:0] diff;
    assign diff   = (val ^ pat[k*W +: W]) & ~msk[k*W +: W];
    assign hit[k] = en[k] && (diff == '0);
  end
endmodule

// File: rtl/cf_ring.sv
module cf_ring #(
  parameter int DW    = 19,
  parameter int PTR_W = 8,
  parameter int BASE  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [DW-1:0]    din,
  input  logic             pop,
  input  logic             ld,
  input  logic [PTR_W-1:0] ld_val,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [DW-1:0]    dout,
  output logic             ne,
  output logic             full,
  output logic             drop
);
  localparam logic [PTR_W-1:0] LO = PTR_W'(BASE);
  localparam logic [PTR_W-1:0] HI = {PTR_W{1'b1}};

  logic [DW-1:0] mem [BASE:(1<<PTR_W)-1];

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == HI) ? LO : p + 1'b1;
  endfunction

  logic store;
  assign ne    = (rd_ptr != wr_ptr);
  assign full  = (step(wr_ptr) == rd_ptr);
  assign store = push && !full;
  assign drop  = push && full;
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (store) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= LO;
      wr_ptr <= LO;
    end else begin
      if (store) wr_ptr <= step(wr_ptr);
      if (ld)                rd_ptr <= (ld_val < LO) ? LO : ld_val;
      else if (pop && ne)    rd_ptr <= step(rd_ptr);
    end
  end
endmodule

// File: rtl/cf_status.sv
module cf_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ne,
  input  logic       full,
  input  logic       rd,
  output logic [1:0] stat
);
  logic ne_d, full_d;
  logic [1:0] rise;
  assign rise = {full && !full_d, ne && !ne_d};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ne_d   <= 1'b0;
      full_d <= 1'b0;
      stat   <= '0;
    end else begin
      ne_d   <= ne;
      full_d <= full;
      stat   <= (rd ? 2'b00 : stat) | rise;
    end
  end
endmodule

// File: rtl/cell_filter_xq.sv
module cell_filter_xq
  import cf_pkg::*;
#(
  parameter int PTR_W  = 8,
  parameter int BASE   = 2,
  parameter int DROP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [VCI_W-1:0]  in_vci,
  input  logic [PT_W-1:0]   in_pt,
  input  logic [VCI_W-1:0]  vci_pat0,
  input  logic [VCI_W-1:0]  vci_msk0,
  input  logic [VCI_W-1:0]  vci_pat1,
  input  logic [VCI_W-1:0]  vci_msk1,
  input  logic [1:0]        vci_en,
  input  logic [PT_W-1:0]   pt_pat0,
  input  logic [PT_W-1:0]   pt_msk0,
  input  logic [PT_W-1:0]   pt_pat1,
  input  logic [PT_W-1:0]   pt_msk1,
  input  logic [1:0]        pt_en,
  output logic              div_valid,
  output logic              div_hit,
  output logic              q_valid,
  input  logic              q_ready,
  output logic [HDR_W-1:0]  q_data,
  output logic [PTR_W-1:0]  rd_ptr,
  output logic [PTR_W-1:0]  wr_ptr,
  input  logic              rp_load,
  input  logic [PTR_W-1:0]  rp_value,
  output logic              flag_full,
  output logic              flag_ne,
  input  logic              stat_rd,
  output logic [1:0]        stat_q,
  output logic              irq,
  output logic [DROP_W-1:0] drop_cnt
);
  logic [1:0] vci_hit, pt_hit;
  logic       hit, drop;
  cf_hdr_t    hdr;

  assign in_ready = 1'b1;
  assign hdr      = '{pt: in_pt, vci: in_vci};

  cf_match #(.W(VCI_W), .N(2)) u_vci (
    .val(in_vci), .pat({vci_pat1, vci_pat0}), .msk({vci_msk1, vci_msk0}),
    .en(vci_en), .hit(vci_hit)
  );

  cf_match #(.W(PT_W), .N(2)) u_pt (
    .val(in_pt), .pat({pt_pat1, pt_pat0}), .msk({pt_msk1, pt_msk0}),
    .en(pt_en), .hit(pt_hit)
  );

  assign hit = |{vci_hit, pt_hit};

  cf_ring #(.DW(HDR_W), .PTR_W(PTR_W), .BASE(BASE)) u_ring (
    .clk(clk), .rst_n(rst_n),
    .push(in_valid && hit), .din(hdr),
    .pop(q_ready), .ld(rp_load), .ld_val(rp_value),
    .rd_ptr(rd_ptr), .wr_ptr(wr_ptr), .dout(q_data),
    .ne(flag_ne), .full(flag_full), .drop(drop)
  );

  assign q_valid = flag_ne;

  cf_status u_stat (
    .clk(clk), .rst_n(rst_n), .ne(flag_ne), .full(flag_full),
    .rd(stat_rd), .stat(stat_q)
  );

  assign irq = |stat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_valid <= 1'b0;
      div_hit   <= 1'b0;
      drop_cnt  <= '0;
    end else begin
      div_valid <= in_valid;
      div_hit   <= in_valid && hit;
      if (drop && drop_cnt != {DROP_W{1'b1}}) drop_cnt <= drop_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/cf_chk.sv
module cf_chk #(
  parameter int PTR_W  = 8,
  parameter int BASE   = 2,
  parameter int DROP_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [1:0]        vci_en,
  input logic [1:0]        pt_en,
  input logic              div_valid,
  input logic              div_hit,
  input logic              q_valid,
  input logic              q_ready,
  input logic [PTR_W-1:0]  rd_ptr,
  input logic [PTR_W-1:0]  wr_ptr,
  input logic              rp_load,
  input logic [PTR_W-1:0]  rp_value,
  input logic              flag_full,
  input logic              stat_rd,
  input logic [1:0]        stat_q,
  input logic [DROP_W-1:0] drop_cnt
);
  localparam logic [PTR_W-1:0] LO = PTR_W'(BASE);

  p_ready_r3: assert property (@(posedge clk) disable iff (!rst_n) in_ready);
  p_div_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> div_valid);
  p_div_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !div_valid && !div_hit);
  p_noen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && vci_en == 2'b00 && pt_en == 2'b00) |=> !div_hit);
  p_empty_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!q_valid && q_ready && !rp_load) |=> rd_ptr == $past(rd_ptr));
  p_full_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_full |=> wr_ptr == $past(wr_ptr));
  p_drop_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    drop_cnt == $past(drop_cnt) || drop_cnt == $past(drop_cnt) + 1'b1);
  p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rp_load |=> rd_ptr == (($past(rp_value) < LO) ? LO : $past(rp_value)));
  p_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ptr >= LO && wr_ptr >= LO);
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_rd && stat_q[0]) |=> stat_q[0]);
endmodule

bind cell_filter_xq cf_chk #(.PTR_W(PTR_W), .BASE(BASE), .DROP_W(DROP_W)) u_chk (.*);

// File: tb/cell_filter_xq_tb.sv
module cell_filter_xq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic in_valid = 0, q_ready = 0, rp_load = 0, stat_rd = 0;
  logic [15:0] in_vci = 0, vci_pat0 = 0, vci_msk0 = 0, vci_pat1 = 0, vci_msk1 = 0;
  logic [2:0]  in_pt = 0, pt_pat0 = 0, pt_msk0 = 0, pt_pat1 = 0, pt_msk1 = 0;
  logic [1:0]  vci_en = 0, pt_en = 0;
  logic [7:0]  rp_value = 0;
  logic        in_ready, div_valid, div_hit, q_valid, flag_full, flag_ne, irq;
  logic [18:0] q_data;
  logic [7:0]  rd_ptr, wr_ptr, drop_cnt;
  logic [1:0]  stat_q;

  cell_filter_xq u_dut (.*);

  int errors = 0, checks = 0;
  int exp_wr = 2, exp_rd = 2, exp_cnt = 0, exp_drop = 0;
  logic [18:0] model [0:255];
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int nxt(input int p);
    return (p == 255) ? 2 : p + 1;
  endfunction

  function automatic int occ(input int w, input int r);
    return (w - r + 254) % 254;
  endfunction

  task automatic push_cell(input logic [15:0] v, input logic [2:0] p, input bit eh);
    @(negedge clk);
    in_valid = 1; in_vci = v; in_pt = p;
    @(negedge clk);
    in_valid = 0;
    chk(div_valid == 1'b1, "R3 div_valid", int'(div_valid), 1);
    chk(div_hit == eh, "R1/R2/R3 div_hit", int'(div_hit), int'(eh));
    if (eh) begin
      if (exp_cnt == 253) exp_drop++;
      else begin
        model[exp_wr] = {p, v};
        exp_wr = nxt(exp_wr);
        exp_cnt++;
      end
    end
  endtask

  task automatic pop_cell();
    @(negedge clk);
    chk(q_valid == 1'b1, "R6 q_valid", int'(q_valid), 1);
    chk(q_data == model[exp_rd], "R6 q_data", int'(q_data), int'(model[exp_rd]));
    q_ready = 1;
    @(negedge clk);
    q_ready = 0;
    exp_rd = nxt(exp_rd);
    exp_cnt--;
    chk(rd_ptr == exp_rd, "R6 rd_ptr advance", rd_ptr, exp_rd);
  endtask

  task automatic load_rd(input logic [7:0] v, input bit with_pop);
    @(negedge clk);
    rp_load = 1; rp_value = v; q_ready = with_pop;
    @(negedge clk);
    rp_load = 0; q_ready = 0;
    exp_rd = (v < 2) ? 2 : int'(v);
    exp_cnt = occ(exp_wr, exp_rd);
    chk(rd_ptr == exp_rd, "R8 rd_ptr load", rd_ptr, exp_rd);
  endtask

  task automatic do_and_pop(input logic [15:0] v, input logic [2:0] p, input bit eh);
    push_cell(v, p, eh);
    if (eh) pop_cell();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog act=hung exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R5 reset state
    chk(rd_ptr == 2 && wr_ptr == 2, "R5 pointers", {rd_ptr, wr_ptr}, 16'h0202);
    chk(!flag_full && !flag_ne && !q_valid, "R5 flags", {flag_full, flag_ne}, 0);
    chk(stat_q == 0 && !irq && drop_cnt == 0, "R5 status/drop", {stat_q, irq, drop_cnt}, 0);
    chk(in_ready == 1'b1, "R3 in_ready", in_ready, 1);

    // Fill the ring: match everything through VCI comparator 0
    vci_msk0 = 16'hFFFF; vci_en = 2'b01;
    for (int i = 0; i < 253; i++) push_cell(16'(i), 3'd0, 1'b1);
    chk(wr_ptr == 255, "R4 wr_ptr after 253", wr_ptr, 255);
    chk(flag_full == 1'b1, "R7 full at 253", flag_full, 1);
    chk(flag_ne == 1'b1, "R6 not empty", flag_ne, 1);
    push_cell(16'h0AAA, 3'd1, 1'b1);
    push_cell(16'h0BBB, 3'd2, 1'b1);
    chk(wr_ptr == 255, "R7 wr_ptr held when full", wr_ptr, 255);
    chk(drop_cnt == exp_drop, "R7 drop_cnt", drop_cnt, exp_drop);
    chk(q_data == 19'd0, "R7 oldest entry intact", q_data, 0);
    // R9 status read and clear
    chk(stat_q == 2'b11 && irq, "R9 status set", {stat_q, irq}, 3'b111);
    @(negedge clk); stat_rd = 1;
    @(negedge clk); stat_rd = 0;
    chk(stat_q == 2'b00 && !irq, "R9 status cleared", {stat_q, irq}, 0);

    pop_cell();                       // rd 2 -> 3
    push_cell(16'd500, 3'd5, 1'b1);   // stored at 255
    chk(wr_ptr == 2, "R4 wr_ptr wraps to 2", wr_ptr, 2);
    chk(flag_full == 1'b1, "R7 full after wrap", flag_full, 1);

    load_rd(8'd100, 1'b0);
    chk(q_data == 19'd98, "R8 data at loaded ptr", q_data, 98);
    load_rd(8'd50, 1'b1);             // load wins over pop
    chk(q_data == 19'd48, "R8 load priority data", q_data, 48);
    load_rd(8'd255, 1'b0);
    pop_cell();                       // rd 255 -> 2 wrap
    chk(rd_ptr == 2, "R6 rd_ptr wraps", rd_ptr, 2);
    chk(!q_valid && !flag_ne, "R6 empty when equal", {q_valid, flag_ne}, 0);
    @(negedge clk); q_ready = 1;
    @(negedge clk); q_ready = 0;
    chk(rd_ptr == 2, "R6 pop on empty ignored", rd_ptr, 2);
    load_rd(8'd0, 1'b0);
    chk(rd_ptr == 2 && !q_valid, "R8 clamp below 2", rd_ptr, 2);
    @(negedge clk); stat_rd = 1;
    @(negedge clk); stat_rd = 0;

    // R2 exhaustive PT sweep on each comparator
    vci_en = 2'b00; vci_msk0 = 16'h0000;
    for (int c = 0; c < 2; c++)
      for (int pp = 0; pp < 8; pp++)
        for (int mm = 0; mm < 8; mm++) begin
          pt_en = (c == 0) ? 2'b01 : 2'b10;
          if (c == 0) begin pt_pat0 = 3'(pp); pt_msk0 = 3'(mm); pt_pat1 = ~3'(pp); pt_msk1 = 3'd0; end
          else        begin pt_pat1 = 3'(pp); pt_msk1 = 3'(mm); pt_pat0 = ~3'(pp); pt_msk0 = 3'd0; end
          for (int t = 0; t < 8; t++)
            do_and_pop(16'(t * 3 + pp), 3'(t), ((t ^ pp) & ~mm & 7) == 0);
        end
    pt_en = 2'b00;

    // R1 VCI sweep of masked nibbles on each comparator
    for (int c = 0; c < 2; c++)
      for (int mi = 0; mi < 4; mi++) begin
        logic [15:0] m, pat;
        m   = (mi == 0) ? 16'h0000 : (mi == 1) ? 16'h000F : (mi == 2) ? 16'h00F0 : 16'hFF0F;
        pat = 16'h1234;
        vci_en = (c == 0) ? 2'b01 : 2'b10;
        if (c == 0) begin vci_pat0 = pat; vci_msk0 = m; vci_pat1 = 16'h0; vci_msk1 = 16'h0; end
        else        begin vci_pat1 = pat; vci_msk1 = m; vci_pat0 = 16'h0; vci_msk0 = 16'h0; end
        for (int k = 0; k < 16; k++) begin
          logic [15:0] v1, v2;
          v1 = 16'h1230 | 16'(k);
          v2 = 16'h1204 | 16'(k << 4);
          do_and_pop(v1, 3'd0, ((v1 ^ pat) & ~m) == 16'h0);
          do_and_pop(v2, 3'd0, ((v2 ^ pat) & ~m) == 16'h0);
        end
      end

    // R3 OR of both comparators, and none enabled
    vci_pat0 = 16'h0100; vci_msk0 = 0; vci_pat1 = 16'h0200; vci_msk1 = 0; vci_en = 2'b11;
    do_and_pop(16'h0100, 3'd0, 1'b1);
    do_and_pop(16'h0200, 3'd0, 1'b1);
    do_and_pop(16'h0300, 3'd0, 1'b0);
    vci_en = 2'b00; pt_msk0 = 3'b111; pt_msk1 = 3'b111; vci_msk0 = 16'hFFFF; vci_msk1 = 16'hFFFF;
    do_and_pop(16'h0100, 3'd3, 1'b0);
    @(negedge clk);
    chk(div_valid == 1'b0, "R3 div_valid idle", div_valid, 0);
    chk(wr_ptr == exp_wr && rd_ptr == exp_rd, "R4 pointers after sweep", {rd_ptr, wr_ptr}, (exp_rd << 8) | exp_wr);
    chk(drop_cnt == exp_drop, "R7 drop_cnt final", drop_cnt, exp_drop);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule